// File: doc/BRIEF.md
# Execute-Stage Bus Master for Loads and Stores

This block sits behind the execute stage of a CPU pipeline and carries loads and stores that target the slow, bus-attached part of the memory map. It uses a two-phase bus: an address phase, in which address, direction, size and byte lanes are shown, and a data phase in the following cycle, which lasts until the slave raises its ready line. Stores are pipelined. Each store's address phase overlaps the data phase of the store before it, so a run of stores with no slave waits moves one store per clock.

Loads are kept strictly serial. A load first waits for every earlier write to finish. It then spends one cycle in its address phase and at least one cycle in its data phase. The CPU is held through both. When the data phase completes, the read word is shifted down to the addressed byte lane, zero- or sign-extended, and sent on the next cycle to the register-file write port with a one-cycle write strobe.

The CPU keeps its request inputs steady while `cpu_stall` is high. A request is taken at the first rising edge where `req_valid` is high and `cpu_stall` is low.

Top module: `lsu_bus_master`

## Requirements
- R1: While reset is active, and once it is released with no request, `bus_trans`, `cpu_stall` and `rf_we` are low.
- R2: If there is no load in flight and the previous data phase is either absent or completing (`bus_ready` high), a store request drives an address phase at once: `bus_trans`=1, `bus_write`=1, with `bus_addr`/`bus_size` taken from the request. `cpu_stall` is 0, so stores go out at one per cycle.
- R3: A store's write data appears on `bus_wdata` in the cycle after its address phase, placed on the addressed byte lanes. It stays there until `bus_ready` is high; `bus_wdata` is 0 when no write data phase is open.
- R4: While a write data phase sees `bus_ready` low, a waiting request keeps `cpu_stall` high, and the address phase of a following store stays on the bus unchanged.
- R5: A load never starts its address phase while a write data phase is open, including the cycle in which that data phase completes. `cpu_stall` stays high while the load waits.
- R6: A load's address phase (`bus_trans`=1, `bus_write`=0) has `cpu_stall`=1. In its data phase `bus_trans`=0 and `cpu_stall` equals the inverse of `bus_ready`.
- R7: The rising edge that ends a load's data phase captures the read data. In the next cycle `rf_we` is high for exactly one cycle, with `rf_waddr` equal to the request's destination index.
- R8: Size code 0 = byte, 1 = halfword, 2 or 3 = word. `bus_be` bit i covers data bits 8i+7..8i. A byte sets bit addr[1:0]; a halfword sets bits {addr[1],0} and {addr[1],1}; a word sets all four bits. `bus_be` is 0 when there is no address phase.
- R9: Load data is shifted right by 8 times the lane offset (addr[1:0] for byte, {addr[1],0} for halfword, 0 for word). It is then zero-extended, or sign-extended when `req_sext`=1.
- R10: With `req_valid` low, no address phase is started and `cpu_stall` is low unless a load data phase is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | CPU presents a load or store |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code (see R8) |
| req_sext | input | 1 | Sign-extend load result |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Store data, right-justified |
| req_rd | input | RW | Destination register index for a load |
| cpu_stall | output | 1 | Pipeline must hold the current request |
| bus_trans | output | 1 | Address phase valid |
| bus_write | output | 1 | Address phase direction |
| bus_size | output | 2 | Address phase size code |
| bus_addr | output | AW | Address phase address |
| bus_be | output | 4 | Address phase byte lanes |
| bus_wdata | output | 32 | Data phase write data |
| bus_rdata | input | 32 | Data phase read data |
| bus_ready | input | 1 | Slave completes the current data phase |
| rf_we | output | 1 | Register-file write strobe |
| rf_waddr | output | RW | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |

## Verification
On every cycle, the checker follows the bus phases from the ports alone. It checks that no read address phase overlaps an open write data phase, that the CPU is held during a load's data phase and that no transfer starts then, and that a stalled store address and write data stay put. It also checks that each completed read produces one write-strobe pulse, that byte lanes match the size, and that stores go out without stalling when the bus is free. Only the bench's scenarios can show the exact lane placement of stored data, the values of shifted and extended loads, the register index delivered, and the cycle counts of a load held behind a stalled store.

// File: rtl/lsbm_pkg.sv
package lsbm_pkg;
  localparam int DW = 32;
  localparam int NB = DW / 8;
  localparam int OW = $clog2(NB);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRD3 = 2'd3
  } xsize_e;

  typedef enum logic {
    CT_IDLE  = 1'b0,
    CT_LDATA = 1'b1
  } ctrl_e;
endpackage

// File: rtl/lane_steer.sv
module lane_steer
  import lsbm_pkg::*;
(
  input  logic [OW-1:0] off,
  input  logic [1:0]    size,
  input  logic [DW-1:0] wdata_in,
  output logic [NB-1:0] be,
  output logic [DW-1:0] wdata_lane
);
  logic [OW-1:0] eoff;

  always_comb begin
    case (xsize_e'(size))
      SZ_BYTE: eoff = off;
      SZ_HALF: eoff = {off[OW-1], 1'b0};
      default: eoff = '0;
    endcase
  end

  for (genvar i = 0; i < NB; i++) begin : g_lane
    localparam logic [OW-1:0] LI = OW'(i);
    always_comb begin
      case (xsize_e'(size))
        SZ_BYTE: be[i] = (off == LI);
        SZ_HALF: be[i] = (off[OW-1] == LI[OW-1]);
        default: be[i] = 1'b1;
      endcase
    end
  end

  assign wdata_lane = wdata_in << {eoff, 3'b000};
endmodule

// File: rtl/load_align.sv
module load_align
  import lsbm_pkg::*;
(
  input  logic [OW-1:0] off,
  input  logic [1:0]    size,
  input  logic          sext,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] value
);
  logic [OW-1:0] eoff;
  logic [DW-1:0] shifted;

  always_comb begin
    case (xsize_e'(size))
      SZ_BYTE: eoff = off;
      SZ_HALF: eoff = {off[OW-1], 1'b0};
      default: eoff = '0;
    endcase
  end

  assign shifted = rdata >> {eoff, 3'b000};

  always_comb begin
    case (xsize_e'(size))
      SZ_BYTE: value = {{(DW-8){sext & shifted[7]}}, shifted[7:0]};
      SZ_HALF: value = {{(DW-16){sext & shifted[15]}}, shifted[15:0]};
      default: value = shifted;
    endcase
  end
endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import lsbm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  input  logic dph_valid,
  input  logic bus_ready,
  output logic bus_trans,
  output logic issue,
  output logic ld_done,
  output logic cpu_stall
);
  ctrl_e state_q, state_d;
  logic  adv;

  assign adv = !dph_valid || bus_ready;

  always_comb begin
    bus_trans = 1'b0;
    issue     = 1'b0;
    ld_done   = 1'b0;
    cpu_stall = 1'b0;
    state_d   = state_q;
    case (state_q)
      CT_IDLE: begin
        bus_trans = req_valid && (req_write || !dph_valid);
        issue     = bus_trans && adv;
        cpu_stall = req_valid && (req_write ? !adv : 1'b1);
        if (issue && !req_write) state_d = CT_LDATA;
      end
      CT_LDATA: begin
        cpu_stall = !bus_ready;
        ld_done   = bus_ready;
        if (bus_ready) state_d = CT_IDLE;
      end
      default: state_d = CT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CT_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/dphase_reg.sv
module dphase_reg
  import lsbm_pkg::*;
#(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic          bus_ready,
  input  logic          in_write,
  input  logic [DW-1:0] in_wdata,
  input  logic [RW-1:0] in_rd,
  input  logic [OW-1:0] in_off,
  input  logic [1:0]    in_size,
  input  logic          in_sext,
  output logic          dph_valid,
  output logic          dph_write,
  output logic [DW-1:0] dph_wdata,
  output logic [RW-1:0] dph_rd,
  output logic [OW-1:0] dph_off,
  output logic [1:0]    dph_size,
  output logic          dph_sext
);
  logic valid_d;

  always_comb begin
    valid_d = dph_valid;
    if (issue)                       valid_d = 1'b1;
    else if (dph_valid && bus_ready) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dph_valid <= 1'b0;
    else        dph_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dph_write <= 1'b0;
      dph_wdata <= '0;
      dph_rd    <= '0;
      dph_off   <= '0;
      dph_size  <= '0;
      dph_sext  <= 1'b0;
    end else if (issue) begin
      dph_write <= in_write;
      dph_wdata <= in_wdata;
      dph_rd    <= in_rd;
      dph_off   <= in_off;
      dph_size  <= in_size;
      dph_sext  <= in_sext;
    end
  end
endmodule

// File: rtl/lsu_bus_master.sv
module lsu_bus_master
  import lsbm_pkg::*;
#(
  parameter int AW = 32,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic          req_sext,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  input  logic [RW-1:0] req_rd,
  output logic          cpu_stall,
  output logic          bus_trans,
  output logic          bus_write,
  output logic [1:0]    bus_size,
  output logic [AW-1:0] bus_addr,
  output logic [3:0]    bus_be,
  output logic [31:0]   bus_wdata,
  input  logic [31:0]   bus_rdata,
  input  logic          bus_ready,
  output logic          rf_we,
  output logic [RW-1:0] rf_waddr,
  output logic [31:0]   rf_wdata
);
  logic [1:0]    rs_q;
  logic          rst_i_n;
  logic          issue, ld_done;
  logic [NB-1:0] be_raw;
  logic [DW-1:0] wlane, ld_value;
  logic          dph_valid, dph_write, dph_sext;
  logic [DW-1:0] dph_wdata;
  logic [RW-1:0] dph_rd;
  logic [OW-1:0] dph_off;
  logic [1:0]    dph_size;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  xfer_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .dph_valid (dph_valid),
    .bus_ready (bus_ready),
    .bus_trans (bus_trans),
    .issue     (issue),
    .ld_done   (ld_done),
    .cpu_stall (cpu_stall)
  );

  lane_steer u_steer (
    .off        (req_addr[OW-1:0]),
    .size       (req_size),
    .wdata_in   (req_wdata),
    .be         (be_raw),
    .wdata_lane (wlane)
  );

  dphase_reg #(.RW(RW)) u_dph (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .issue     (issue),
    .bus_ready (bus_ready),
    .in_write  (req_write),
    .in_wdata  (wlane),
    .in_rd     (req_rd),
    .in_off    (req_addr[OW-1:0]),
    .in_size   (req_size),
    .in_sext   (req_sext),
    .dph_valid (dph_valid),
    .dph_write (dph_write),
    .dph_wdata (dph_wdata),
    .dph_rd    (dph_rd),
    .dph_off   (dph_off),
    .dph_size  (dph_size),
    .dph_sext  (dph_sext)
  );

  load_align u_align (
    .off   (dph_off),
    .size  (dph_size),
    .sext  (dph_sext),
    .rdata (bus_rdata),
    .value (ld_value)
  );

  assign bus_write = req_write;
  assign bus_size  = req_size;
  assign bus_addr  = req_addr;
  assign bus_be    = bus_trans ? be_raw : '0;
  assign bus_wdata = (dph_valid && dph_write) ? dph_wdata : '0;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) rf_we <= 1'b0;
    else          rf_we <= ld_done;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rf_waddr <= '0;
      rf_wdata <= '0;
    end else if (ld_done) begin
      rf_waddr <= dph_rd;
      rf_wdata <= ld_value;
    end
  end
endmodule

// File: rtl/lsbm_checker.sv
module lsbm_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          cpu_stall,
  input logic          bus_trans,
  input logic          bus_write,
  input logic [1:0]    bus_size,
  input logic [AW-1:0] bus_addr,
  input logic [3:0]    bus_be,
  input logic [31:0]   bus_wdata,
  input logic          bus_ready,
  input logic          rf_we
);
  logic ph_q, phwr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= 1'b0;
      phwr_q <= 1'b0;
    end else if (bus_trans && (!ph_q || bus_ready)) begin
      ph_q   <= 1'b1;
      phwr_q <= bus_write;
    end else if (ph_q && bus_ready) begin
      ph_q   <= 1'b0;
    end
  end

  assert_store_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_trans && bus_write && (!ph_q || bus_ready) |-> !cpu_stall);

  assert_wdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q && phwr_q && !bus_ready |=> $stable(bus_wdata));

  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q && !bus_ready && bus_trans |=> bus_trans && $stable(bus_addr));

  assert_rd_after_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_trans && !bus_write |-> !ph_q);

  assert_ld_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q && !phwr_q && !bus_ready |-> cpu_stall);

  assert_ld_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q && !phwr_q |-> !bus_trans);

  assert_rf_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q && !phwr_q && bus_ready |=> rf_we);

  assert_rf_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we);

  assert_be_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_trans && bus_size == 2'd0 |-> $countones(bus_be) == 1);

  assert_be_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_trans |-> bus_be == 4'b0000);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !bus_trans);
endmodule

bind lsu_bus_master lsbm_checker #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .cpu_stall (cpu_stall),
  .bus_trans (bus_trans),
  .bus_write (bus_write),
  .bus_size  (bus_size),
  .bus_addr  (bus_addr),
  .bus_be    (bus_be),
  .bus_wdata (bus_wdata),
  .bus_ready (bus_ready),
  .rf_we     (rf_we)
);

// File: tb/sim_lsu_bus_master.sv
`timescale 1ns/1ps
module sim_lsu_bus_master;
  localparam int AW = 32;
  localparam int RW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write, req_sext;
  logic [1:0]    req_size;
  logic [AW-1:0] req_addr;
  logic [31:0]   req_wdata;
  logic [RW-1:0] req_rd;
  logic          cpu_stall, bus_trans, bus_write;
  logic [1:0]    bus_size;
  logic [AW-1:0] bus_addr;
  logic [3:0]    bus_be;
  logic [31:0]   bus_wdata, bus_rdata;
  logic          bus_ready;
  logic          rf_we;
  logic [RW-1:0] rf_waddr;
  logic [31:0]   rf_wdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lsu_bus_master #(.AW(AW), .RW(RW)) u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, then settle to just before the rising edge
  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic settle();
    #3;
  endtask

  task automatic idle_req();
    req_valid = 1'b0; req_write = 1'b0; req_size = 2'd2; req_sext = 1'b0;
    req_addr = '0; req_wdata = '0; req_rd = '0;
  endtask

  task automatic set_req(logic wr, logic [1:0] sz, logic sx, logic [31:0] a,
                         logic [31:0] d, logic [RW-1:0] rd);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_sext = sx;
    req_addr = a; req_wdata = d; req_rd = rd;
  endtask

  task automatic t_reset();
    chk("R1 trans in reset", 32'(bus_trans), 0);
    chk("R1 stall in reset", 32'(cpu_stall), 0);
    chk("R1 rf_we in reset", 32'(rf_we), 0);
  endtask

  task automatic t_idle();
    nxt(); idle_req(); bus_ready = 1'b1; settle();
    chk("R10 no trans when idle", 32'(bus_trans), 0);
    chk("R10 no stall when idle", 32'(cpu_stall), 0);
    chk("R1 rf_we after reset", 32'(rf_we), 0);
  endtask

  task automatic t_store_stream();
    nxt(); bus_ready = 1'b1; set_req(1, 2'd2, 0, 32'h100, 32'hA0A0_0001, 0); settle();
    chk("R2 trans", 32'(bus_trans), 1);
    chk("R2 write", 32'(bus_write), 1);
    chk("R2 addr", bus_addr, 32'h100);
    chk("R8 word be", 32'(bus_be), 32'hF);
    chk("R2 no stall", 32'(cpu_stall), 0);
    nxt(); set_req(1, 2'd2, 0, 32'h104, 32'hB0B0_0002, 0); settle();
    chk("R2 second addr", bus_addr, 32'h104);
    chk("R2 second no stall", 32'(cpu_stall), 0);
    chk("R3 first wdata", bus_wdata, 32'hA0A0_0001);
    nxt(); set_req(1, 2'd2, 0, 32'h108, 32'hC0C0_0003, 0); settle();
    chk("R2 third no stall", 32'(cpu_stall), 0);
    chk("R3 second wdata", bus_wdata, 32'hB0B0_0002);
    nxt(); idle_req(); settle();
    chk("R3 third wdata", bus_wdata, 32'hC0C0_0003);
    chk("R10 trans idle", 32'(bus_trans), 0);
    nxt(); settle();
    chk("R3 wdata cleared", bus_wdata, 32'h0);
  endtask

  task automatic t_store_wait();
    nxt(); bus_ready = 1'b1; set_req(1, 2'd2, 0, 32'h200, 32'h1111_2222, 0); settle();
    chk("R2 A trans", 32'(bus_trans), 1);
    nxt(); bus_ready = 1'b0; set_req(1, 2'd2, 0, 32'h204, 32'h3333_4444, 0); settle();
    chk("R4 stall on wait", 32'(cpu_stall), 1);
    chk("R4 B addr shown", bus_addr, 32'h204);
    chk("R3 A wdata", bus_wdata, 32'h1111_2222);
    nxt(); settle();
    chk("R4 stall still", 32'(cpu_stall), 1);
    chk("R4 B trans held", 32'(bus_trans), 1);
    chk("R3 A wdata held", bus_wdata, 32'h1111_2222);
    nxt(); bus_ready = 1'b1; settle();
    chk("R4 stall released", 32'(cpu_stall), 0);
    nxt(); idle_req(); settle();
    chk("R3 B wdata", bus_wdata, 32'h3333_4444);
    nxt(); settle();
  endtask

  task automatic t_lanes();
    nxt(); bus_ready = 1'b1; set_req(1, 2'd0, 0, 32'h301, 32'h0000_00AB, 0); settle();
    chk("R8 byte be off1", 32'(bus_be), 32'h2);
    nxt(); set_req(1, 2'd1, 0, 32'h302, 32'h0000_1234, 0); settle();
    chk("R3 byte lane data", bus_wdata, 32'h0000_AB00);
    chk("R8 half be off2", 32'(bus_be), 32'hC);
    nxt(); set_req(1, 2'd0, 0, 32'h303, 32'h0000_0077, 0); settle();
    chk("R3 half lane data", bus_wdata, 32'h1234_0000);
    chk("R8 byte be off3", 32'(bus_be), 32'h8);
    nxt(); idle_req(); settle();
    chk("R3 byte off3 data", bus_wdata, 32'h7700_0000);
    nxt(); settle();
  endtask

  task automatic t_load_after_store();
    nxt(); bus_ready = 1'b1; set_req(1, 2'd2, 0, 32'h400, 32'h0000_0011, 0); settle();
    nxt(); bus_ready = 1'b0; set_req(0, 2'd2, 0, 32'h500, 32'h0, 5'd3); settle();
    chk("R5 no read while write waits", 32'(bus_trans), 0);
    chk("R5 stall while waiting", 32'(cpu_stall), 1);
    nxt(); bus_ready = 1'b1; settle();
    chk("R5 no read in write completion cycle", 32'(bus_trans), 0);
    chk("R5 stall in completion cycle", 32'(cpu_stall), 1);
    nxt(); settle();
    chk("R6 read addr phase", 32'(bus_trans), 1);
    chk("R6 read dir", 32'(bus_write), 0);
    chk("R6 read addr", bus_addr, 32'h500);
    chk("R6 stall in addr phase", 32'(cpu_stall), 1);
    nxt(); bus_rdata = 32'hCAFE_0001; settle();
    chk("R6 no trans in data phase", 32'(bus_trans), 0);
    chk("R6 stall released on ready", 32'(cpu_stall), 0);
    nxt(); idle_req(); settle();
    chk("R7 rf_we pulse", 32'(rf_we), 1);
    chk("R7 rf index", 32'(rf_waddr), 3);
    chk("R7 rf data", rf_wdata, 32'hCAFE_0001);
    nxt(); settle();
    chk("R7 rf_we single", 32'(rf_we), 0);
  endtask

  task automatic t_load_wait();
    nxt(); bus_ready = 1'b1; set_req(0, 2'd2, 0, 32'h600, 32'h0, 5'd9); settle();
    chk("R6 addr phase stall", 32'(cpu_stall), 1);
    nxt(); bus_ready = 1'b0; bus_rdata = 32'hDEAD_DEAD; settle();
    chk("R6 data wait stall", 32'(cpu_stall), 1);
    chk("R6 data wait no trans", 32'(bus_trans), 0);
    nxt(); settle();
    chk("R6 data wait stall 2", 32'(cpu_stall), 1);
    chk("R7 no early strobe", 32'(rf_we), 0);
    nxt(); bus_ready = 1'b1; bus_rdata = 32'h1234_5678; settle();
    chk("R6 ready ends stall", 32'(cpu_stall), 0);
    nxt(); idle_req(); settle();
    chk("R7 strobe after wait", 32'(rf_we), 1);
    chk("R7 index after wait", 32'(rf_waddr), 9);
    chk("R7 data after wait", rf_wdata, 32'h1234_5678);
    nxt(); settle();
  endtask

  task automatic do_load(string tag, logic [1:0] sz, logic sx, logic [31:0] a,
                         logic [31:0] rd_word, logic [31:0] exp);
    nxt(); bus_ready = 1'b1; set_req(0, sz, sx, a, 32'h0, 5'd7); settle();
    nxt(); bus_rdata = rd_word; settle();
    nxt(); idle_req(); settle();
    chk({tag, " strobe"}, 32'(rf_we), 1);
    chk(tag, rf_wdata, exp);
  endtask

  task automatic t_extend();
    do_load("R9 signed byte off2",   2'd0, 1, 32'h702, 32'h0080_0000, 32'hFFFF_FF80);
    do_load("R9 unsigned byte off2", 2'd0, 0, 32'h702, 32'h0080_0000, 32'h0000_0080);
    do_load("R9 unsigned half off2", 2'd1, 0, 32'h706, 32'h8001_5555, 32'h0000_8001);
    do_load("R9 signed half off0",   2'd1, 1, 32'h704, 32'h0000_9abc, 32'hFFFF_9ABC);
    do_load("R9 word ignores sext",  2'd2, 1, 32'h708, 32'h8765_4321, 32'h8765_4321);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_ready = 1'b1; bus_rdata = '0; idle_req();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_idle();
    t_store_stream();
    t_store_wait();
    t_lanes();
    t_load_after_store();
    t_load_wait();
    t_extend();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule